// File: doc/BRIEF.md
# Sample Stream Demultiplexer with Decimation

This block takes a stream of `DATA_W`-bit samples, at most one per clock cycle and each qualified by `smp_vld`, and distributes them over two output ports, A and B. A configuration word chooses one of three routing modes. In single-port mode every sample leaves on port A. In paired mode, consecutive samples are collected in pairs: the earlier sample leaves on port A and the later one leaves on port B, in the same cycle. In decimation mode only one valid sample in `DEC_FACTOR` is kept, and it leaves on port A.

Each port has a one-cycle valid strobe and an output enable. The output enable models whether the port drives its lines; a port that is not enabled reads as zero. The path from input to port has a fixed latency of `LATENCY` clock cycles. The earlier sample of a pair waits one extra cycle for its partner. A change of routing mode starts a one-cycle synchronous flush. The flush discards everything in flight and restarts the pairing and the decimation phase.

The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer, so the block leaves reset two rising edges after `rst_n` goes high.

Top module: `smp_demux`

## Requirements
- R1: While reset is active, `a_vld`, `b_vld`, `a_oe`, `b_oe`, `a_data` and `b_data` are all 0, and the mode is single-port.
- R2: The mode is decoded from `cfg_word`. If bit 7 is 1, the mode is decimation, whatever bit 0 holds. If bit 7 is 0 and bit 0 is 1, the mode is paired. If both bits are 0, the mode is single-port.
- R3: In single-port mode, a sample presented with `smp_vld` in cycle t appears on `a_data` with `a_vld` high in cycle t+`LATENCY`. `b_oe` is 0 in this mode.
- R4: In paired mode, the valid samples count from 0 after each flush. Even-numbered sample N goes to port A and sample N+1 goes to port B. Both ports strobe together in the cycle that is `LATENCY` cycles after sample N+1 was presented, so sample N sees one cycle more of latency. `b_oe` is 1 only in this mode.
- R5: In decimation mode, valid samples number 0, 1, 2 and so on after each flush. Only the samples whose number is a multiple of `DEC_FACTOR` reach port A, `LATENCY` cycles after they were presented. Port B stays disabled and never strobes.
- R6: Cycles with `smp_vld` low do not advance the pairing or the decimation count.
- R7: When the decoded mode differs from the current mode, the next edge performs a flush. It switches the mode and discards every sample in flight, including the sample presented in that cycle. It also resets the pairing and the decimation count. Neither port strobes in the cycle after the flush edge.
- R8: Bits 1 to 6 of `cfg_word` have no effect, and changing them causes no flush.
- R9: A port's data output holds its last value in cycles without a strobe.
- R10: `a_oe` is 1 from the first edge after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 8 | Configuration word; bit 7 selects decimation, bit 0 selects paired mode |
| smp_vld | input | 1 | Input sample qualifier |
| smp_data | input | DATA_W | Input sample |
| a_data | output | DATA_W | Port A data |
| a_vld | output | 1 | Port A update strobe |
| a_oe | output | 1 | Port A output enable |
| b_data | output | DATA_W | Port B data (zero while disabled) |
| b_vld | output | 1 | Port B update strobe |
| b_oe | output | 1 | Port B output enable |

## Verification
The bench builds the block with its default values: 8-bit samples, a latency of 3 and a decimation factor of 16. With these values the counter wraps several times within a few hundred cycles, and the pair hold register can be caught at an odd phase when a flush arrives. The short pipeline lets mode switches land while samples are still in every stage. It also allows an exact count of the cycles from input to port in the single-port mode.

// File: rtl/smp_demux_pkg.sv
package smp_demux_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_PAIR   = 2'd1,
    MODE_DECIM  = 2'd2
  } route_mode_e;

  localparam int CFG_W        = 8;
  localparam int CFG_DEC_BIT  = 7;
  localparam int CFG_PAIR_BIT = 0;
endpackage

// File: rtl/smp_demux_cfg.sv
module smp_demux_cfg
  import smp_demux_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  output route_mode_e      mode_o,
  output logic             flush_o
);
  route_mode_e mode_q, mode_d;
  logic        unused_cfg_bits;

  assign unused_cfg_bits = ^cfg_word[CFG_DEC_BIT-1:CFG_PAIR_BIT+1];

  // R2: decimation bit has priority over the pair bit
  always_comb begin
    if (cfg_word[CFG_DEC_BIT])       mode_d = MODE_DECIM;
    else if (cfg_word[CFG_PAIR_BIT]) mode_d = MODE_PAIR;
    else                             mode_d = MODE_SINGLE;
  end

  assign flush_o = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_SINGLE;
    else if (flush_o) mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/smp_demux_pipe.sv
module smp_demux_pipe #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  output logic          out_vld,
  output logic [DW-1:0] out_data
);
  logic [STAGES-1:0] vld_q;
  logic [DW-1:0]     dat_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic          src_vld;
    logic [DW-1:0] src_dat;
    if (i == 0) begin : g_head
      assign src_vld = in_vld;
      assign src_dat = in_data;
    end else begin : g_body
      assign src_vld = vld_q[i-1];
      assign src_dat = dat_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        dat_q[i] <= '0;
      end else begin
        vld_q[i] <= src_vld & ~flush_i;
        if (src_vld) dat_q[i] <= src_dat;
      end
    end
  end

  assign out_vld  = vld_q[STAGES-1];
  assign out_data = dat_q[STAGES-1];
endmodule

// File: rtl/smp_demux_route.sv
module smp_demux_route
  import smp_demux_pkg::*;
#(
  parameter int DW  = 8,
  parameter int DEC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  route_mode_e   mode_i,
  input  logic          flush_i,
  input  logic          s_vld,
  input  logic [DW-1:0] s_data,
  output logic [DW-1:0] a_data_o,
  output logic          a_vld_o,
  output logic          a_oe_o,
  output logic [DW-1:0] b_data_o,
  output logic          b_vld_o,
  output logic          b_oe_o
);
  localparam int CW = (DEC > 2) ? $clog2(DEC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEC - 1);

  logic          tog_q, tog_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] hold_q, hold_d, a_q, a_d, b_q, b_d;
  logic          va_q, va_d, vb_q, vb_d, oe_a_q;

  always_comb begin
    tog_d  = tog_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    a_d    = a_q;
    b_d    = b_q;
    va_d   = 1'b0;
    vb_d   = 1'b0;
    if (flush_i) begin
      tog_d = 1'b0;
      cnt_d = '0;
    end else if (s_vld) begin
      unique case (mode_i)
        MODE_PAIR: begin
          if (!tog_q) begin
            hold_d = s_data;
            tog_d  = 1'b1;
          end else begin
            a_d   = hold_q;
            b_d   = s_data;
            va_d  = 1'b1;
            vb_d  = 1'b1;
            tog_d = 1'b0;
          end
        end
        MODE_DECIM: begin
          if (cnt_q == '0) begin
            a_d  = s_data;
            va_d = 1'b1;
          end
          cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        end
        default: begin
          a_d  = s_data;
          va_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      va_q   <= 1'b0;
      vb_q   <= 1'b0;
      oe_a_q <= 1'b0;
    end else begin
      tog_q  <= tog_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      a_q    <= a_d;
      b_q    <= b_d;
      va_q   <= va_d;
      vb_q   <= vb_d;
      oe_a_q <= 1'b1;
    end
  end

  assign b_oe_o   = (mode_i == MODE_PAIR);
  assign a_data_o = a_q;
  assign a_vld_o  = va_q;
  assign a_oe_o   = oe_a_q;
  assign b_data_o = b_oe_o ? b_q : '0;
  assign b_vld_o  = vb_q;

  // R4: a completed pair needs two fresh samples, so no back-to-back B strobes
  a_r4_pair_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    vb_q |=> !vb_q);
  // R5: a kept sample leaves the phase counter at one
  a_r5_dec_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (va_q && mode_i == MODE_DECIM) |-> (cnt_q == CW'(1)));
  // R5: decimated strobes never repeat on the next edge
  a_r5_dec_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (va_q && mode_i == MODE_DECIM) |=> !va_q);
  // R3 / R5: port B is silent outside the paired mode
  a_r3_b_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_PAIR) |-> !vb_q);
endmodule

// File: rtl/smp_demux.sv
module smp_demux
  import smp_demux_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LATENCY    = 3,
  parameter int DEC_FACTOR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_data,
  output logic [DATA_W-1:0] a_data,
  output logic              a_vld,
  output logic              a_oe,
  output logic [DATA_W-1:0] b_data,
  output logic              b_vld,
  output logic              b_oe
);
  localparam int PIPE_STAGES = LATENCY - 1;

  logic [1:0]        rsync_q;
  logic              rst_int_n;
  route_mode_e       mode;
  logic              flush;
  logic              p_vld;
  logic [DATA_W-1:0] p_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  smp_demux_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_word (cfg_word),
    .mode_o   (mode),
    .flush_o  (flush)
  );

  smp_demux_pipe #(.DW(DATA_W), .STAGES(PIPE_STAGES)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .flush_i  (flush),
    .in_vld   (smp_vld),
    .in_data  (smp_data),
    .out_vld  (p_vld),
    .out_data (p_data)
  );

  smp_demux_route #(.DW(DATA_W), .DEC(DEC_FACTOR)) u_route (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .mode_i   (mode),
    .flush_i  (flush),
    .s_vld    (p_vld),
    .s_data   (p_data),
    .a_data_o (a_data),
    .a_vld_o  (a_vld),
    .a_oe_o   (a_oe),
    .b_data_o (b_data),
    .b_vld_o  (b_vld),
    .b_oe_o   (b_oe)
  );

  // R7: the edge that flushes leaves both ports without a strobe
  a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    flush |=> (!a_vld && !b_vld));
  // R10: port A stays enabled once out of reset
  a_r10_a_enabled: assert property (@(posedge clk) disable iff (!rst_int_n)
    a_vld |-> a_oe);
endmodule

// File: tb/smp_demux_tb.sv
module smp_demux_tb_top;
  localparam int DW  = 8;
  localparam int LAT = 3;
  localparam int DEC = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    cfg_word;
  logic          smp_vld;
  logic [DW-1:0] smp_data;
  logic [DW-1:0] a_data, b_data;
  logic          a_vld, a_oe, b_vld, b_oe;

  always #4 clk = ~clk;

  smp_demux #(.DATA_W(DW), .LATENCY(LAT), .DEC_FACTOR(DEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .smp_vld(smp_vld),
    .smp_data(smp_data), .a_data(a_data), .a_vld(a_vld), .a_oe(a_oe),
    .b_data(b_data), .b_vld(b_vld), .b_oe(b_oe)
  );

  int n_chk = 0, n_bad = 0, edge_no = 0;
  bit done = 0, checking = 0;

  // behavioural reference state
  int            m_mode, m_tog, m_cnt;
  logic [DW-1:0] m_hold, m_a, m_b;
  bit            m_va, m_vb, m_oea;
  logic [DW-1:0] q_dat[$];
  int            q_at[$];

  function automatic int mode_of(logic [7:0] c);
    if (c[7]) return 2;
    if (c[0]) return 1;
    return 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at edge %0d", req, what, act, exp, edge_no);
    end
  endtask

  task automatic model_edge(logic [7:0] c, bit v, logic [DW-1:0] d);
    int nm;
    m_oea = 1; m_va = 0; m_vb = 0;
    nm = mode_of(c);
    if (nm != m_mode) begin
      m_mode = nm; q_dat.delete(); q_at.delete(); m_tog = 0; m_cnt = 0;
    end else begin
      if (q_at.size() > 0 && q_at[0] == edge_no) begin
        logic [DW-1:0] s;
        s = q_dat.pop_front();
        void'(q_at.pop_front());
        if (m_mode == 0) begin m_a = s; m_va = 1; end
        else if (m_mode == 1) begin
          if (m_tog == 0) begin m_hold = s; m_tog = 1; end
          else begin m_a = m_hold; m_b = s; m_va = 1; m_vb = 1; m_tog = 0; end
        end else begin
          if (m_cnt == 0) begin m_a = s; m_va = 1; end
          m_cnt = (m_cnt + 1) % DEC;
        end
      end
      if (v) begin q_dat.push_back(d); q_at.push_back(edge_no + LAT - 1); end
    end
  endtask

  task automatic step(logic [7:0] c, bit v, logic [DW-1:0] d, string req);
    cfg_word = c; smp_vld = v; smp_data = d;
    @(posedge clk);
    model_edge(c, v, d);
    edge_no++;
    @(negedge clk);
    if (checking) begin
      chk(req, "a_vld", a_vld, m_va);
      chk(req, "b_vld", b_vld, m_vb);
      chk("R10", "a_oe", a_oe, m_oea);
      chk(req, "b_oe", b_oe, m_mode == 1);
      chk((m_va || m_vb) ? req : "R9", "a_data", a_data, m_a);
      chk(req, "b_data", b_data, (m_mode == 1) ? m_b : 0);
    end
  endtask

  task automatic burst(logic [7:0] c, int n, int gap_pct, string req);
    for (int i = 0; i < n; i++)
      step(c, ($urandom % 100) >= gap_pct, DW'($urandom), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    m_mode = 0; m_tog = 0; m_cnt = 0; m_hold = 0; m_a = 0; m_b = 0;
    m_va = 0; m_vb = 0; m_oea = 0;
    rst_n = 0; cfg_word = 8'h01; smp_vld = 1; smp_data = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state even with active inputs
    chk("R1", "a_vld", a_vld, 0); chk("R1", "b_vld", b_vld, 0);
    chk("R1", "a_oe", a_oe, 0);   chk("R1", "b_oe", b_oe, 0);
    chk("R1", "a_data", a_data, 0); chk("R1", "b_data", b_data, 0);
    cfg_word = 8'h00; smp_vld = 0;
    rst_n = 1;
    for (int i = 0; i < 4; i++) step(8'h00, 0, 0, "R1");
    checking = 1;

    // R3: exact latency count in single-port mode
    step(8'h00, 1, 8'hC3, "R3");
    n = 1;
    while (!a_vld && n < 10) begin step(8'h00, 0, 0, "R3"); n++; end
    chk("R3", "latency", n, LAT);
    chk("R3", "a_data", a_data, 8'hC3);
    step(8'h00, 0, 0, "R9");
    chk("R9", "a_hold", a_data, 8'hC3);

    burst(8'h00, 40, 0, "R3");
    burst(8'h00, 40, 30, "R6");
    // R8: unused bits toggle mid-stream
    for (int i = 0; i < 30; i++) step(8'h7E & 8'($urandom), 1, DW'($urandom), "R8");

    burst(8'h01, 40, 0, "R4");
    burst(8'h3D, 40, 40, "R6");
    // R7: odd pair phase then flush into decimation
    step(8'h01, 1, 8'h11, "R7");
    burst(8'h80, 80, 0, "R5");
    burst(8'h81, 120, 35, "R2");
    burst(8'h00, 10, 0, "R7");
    burst(8'h01, 7, 0, "R7");
    burst(8'h80, 20, 0, "R7");
    // R7: rapid mode flipping while samples are in flight
    for (int i = 0; i < 60; i++) step(8'($urandom) & 8'h81, 1, DW'($urandom), "R7");
    burst(8'h01, 50, 20, "R4");
    burst(8'h80, 70, 10, "R5");
    burst(8'h00, 10, 0, "R3");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule